// File: doc/BRIEF.md
# Operand Effective-Address Generator

This block turns the 9-bit operand field of a stack-machine instruction into an operand location and fetches the operand. The top three bits of the field choose an addressing base. The low six bits are an unsigned displacement. Four base codes address consecutive 64-word windows inside the current function object. One code addresses a constants page. Two codes index the stack relative to the local frame or the argument frame. The last code takes the top of stack and pops it.

Memory operands are read through a request/acknowledge handshake. Each memory word carries a tag. One tag value marks a forwarding cell, whose low address bits name the next cell to read. For the four function-relative codes, the block keeps reading until it reaches a cell that is not a forwarding cell. For the constants page it reads exactly once. A chain that keeps forwarding is cut off with an error after a fixed number of hops.

Each request ends with a one-cycle `done` pulse. The final address or stack index, the data word, its tag, an `is_stack` flag and an error flag are then held until the next request.

Top module: `opnd_ea_gen`

## Requirements
- R1: After reset, `done`, `mem_req`, `stk_pop` and `err` are all 0.
- R2: For base codes 0 to 3 (field bits 8:6), the first memory read goes to `fn_ptr + 64*base + displacement`, where the displacement is field bits 5:0. With a non-forwarding cell there, `ea_out` is that address, `data_out`/`tag_out` hold the cell, and `is_stack` is 0.
- R3: Base code 4 reads `const_base + displacement` exactly once. A forwarding tag there is returned as data and is not followed.
- R4: Base code 5 drives `stk_idx = local_ptr + displacement`. It returns `stk_rdata` at that index with `is_stack` = 1 and `ea_out` = the index.
- R5: Base code 6 drives `stk_idx = arg_ptr + displacement + 1` and returns the stack word there, with `is_stack` = 1.
- R6: Base code 7 with `is_store` = 0 returns `stk_top` as data with `is_stack` = 1 and `ea_out` = 0. `stk_pop` is high for exactly the `done` cycle. The displacement has no effect.
- R7: Base code 7 with `is_store` = 1 sets `err` and does not pulse `stk_pop`.
- R8: In function-relative modes, a cell whose tag equals `FWD_TAG` (default 7) sends the next read to its data bits `ADDR_W-1:0`. `ea_out` is the address of the last cell read, and `data_out`/`tag_out` hold its contents.
- R9: A chain of up to `MAX_HOPS` (16) hops finishes without error, using `MAX_HOPS+1` reads. If the cell read after the 16th hop still forwards, `err` is set, `ea_out` is that cell's address, and no further read is issued.
- R10: `done` is a one-cycle pulse. `mem_req` is low while `done` is high. A `start` while a request is in progress is ignored.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_req` stays high and `mem_addr` is stable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving `opnd_field` |
| opnd_field | input | 9 | Base code (8:6) and displacement (5:0) |
| is_store | input | 1 | The operand is used as a store destination |
| fn_ptr | input | ADDR_W | Current function object address |
| const_base | input | ADDR_W | Constants page base address |
| local_ptr | input | ADDR_W | Local frame stack index |
| arg_ptr | input | ADDR_W | Argument frame stack index |
| stk_top | input | DATA_W | Current top-of-stack word |
| stk_idx | output | ADDR_W | Stack index being read |
| stk_rdata | input | DATA_W | Stack word at `stk_idx` (combinational) |
| stk_pop | output | 1 | Pop request, one cycle |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | ADDR_W | Memory read address |
| mem_ack | input | 1 | Read data valid, one cycle |
| mem_rtag | input | TAG_W | Tag of the word read |
| mem_rdata | input | DATA_W | Data of the word read |
| done | output | 1 | Result valid pulse |
| is_stack | output | 1 | Result is a stack location |
| err | output | 1 | Pop used as store, or hop limit exceeded |
| ea_out | output | ADDR_W | Final memory address or stack index |
| data_out | output | DATA_W | Operand data |
| tag_out | output | TAG_W | Operand tag (0 for stack operands) |

## Verification
Two events can meet on a single memory acknowledge: a forwarding tag that asks for another hop, and the hop counter reaching its limit. The bench builds forwarding chains exactly 16 and 17 cells long, under random acknowledge latency. It then checks the reported address, the error flag and the number of reads the memory model served. A second overlap is a fresh `start` that arrives while a chain is still being chased. The bench raises `start` with an unrelated operand in the middle of a chase. It expects that result, and the following one, to match the first operand only.

// File: rtl/opnd_ea_pkg.sv
package opnd_ea_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_STK} ea_state_t;
  typedef enum logic [1:0] {K_MEM, K_STACK, K_POP} ea_kind_t;
  localparam logic [2:0] BASE_CONST = 3'd4;
  localparam logic [2:0] BASE_LOCAL = 3'd5;
  localparam logic [2:0] BASE_ARG   = 3'd6;
  localparam logic [2:0] BASE_POP   = 3'd7;
endpackage

// File: rtl/opnd_base_sel.sv
module opnd_base_sel
  import opnd_ea_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 6
) (
  input  logic [2:0]        sel,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] fn_ptr,
  input  logic [ADDR_W-1:0] const_base,
  input  logic [ADDR_W-1:0] local_ptr,
  input  logic [ADDR_W-1:0] arg_ptr,
  output logic [ADDR_W-1:0] addr,
  output ea_kind_t          kind,
  output logic              follow
);
  localparam int WIN = 1 << DISP_W;

  logic [ADDR_W-1:0] disp_x;
  logic [ADDR_W-1:0] win_addr [4];

  assign disp_x = ADDR_W'(disp);

  for (genvar g = 0; g < 4; g++) begin : g_win
    assign win_addr[g] = fn_ptr + ADDR_W'(g * WIN) + disp_x;
  end

  always_comb begin
    addr   = win_addr[sel[1:0]];
    kind   = K_MEM;
    follow = 1'b1;
    case (sel)
      BASE_CONST: begin
        addr   = const_base + disp_x;
        follow = 1'b0;
      end
      BASE_LOCAL: begin
        addr   = local_ptr + disp_x;
        kind   = K_STACK;
        follow = 1'b0;
      end
      BASE_ARG: begin
        addr   = arg_ptr + disp_x + ADDR_W'(1);
        kind   = K_STACK;
        follow = 1'b0;
      end
      BASE_POP: begin
        addr   = '0;
        kind   = K_POP;
        follow = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/opnd_fwd_chaser.sv
module opnd_fwd_chaser #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W = 3,
  parameter logic [TAG_W-1:0] FWD_TAG = '1,
  parameter int MAX_HOPS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [ADDR_W-1:0] launch_addr,
  input  logic              follow,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [TAG_W-1:0]  mem_rtag,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fin,
  output logic              fin_err,
  output logic [DATA_W-1:0] fin_data,
  output logic [TAG_W-1:0]  fin_tag
);
  localparam int HOP_W = $clog2(MAX_HOPS + 1);

  logic             active;
  logic             follow_r;
  logic [HOP_W-1:0] hops;
  logic             is_fwd;

  assign mem_req = active;
  assign is_fwd  = follow_r && (mem_rtag == FWD_TAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      follow_r <= 1'b0;
      hops     <= '0;
      mem_addr <= '0;
      fin      <= 1'b0;
      fin_err  <= 1'b0;
      fin_data <= '0;
      fin_tag  <= '0;
    end else begin
      fin <= 1'b0;
      if (!active && launch) begin
        active   <= 1'b1;
        mem_addr <= launch_addr;
        follow_r <= follow;
        hops     <= '0;
      end else if (active && mem_ack) begin
        if (is_fwd && hops != HOP_W'(MAX_HOPS)) begin
          mem_addr <= mem_rdata[ADDR_W-1:0];
          hops     <= hops + 1'b1;
        end else begin
          active   <= 1'b0;
          fin      <= 1'b1;
          fin_err  <= is_fwd;
          fin_data <= mem_rdata;
          fin_tag  <= mem_rtag;
        end
      end
    end
  end
endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen
  import opnd_ea_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W = 3,
  parameter int DISP_W = 6,
  parameter logic [TAG_W-1:0] FWD_TAG = '1,
  parameter int MAX_HOPS = 16,
  localparam int FIELD_W = DISP_W + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FIELD_W-1:0] opnd_field,
  input  logic               is_store,
  input  logic [ADDR_W-1:0]  fn_ptr,
  input  logic [ADDR_W-1:0]  const_base,
  input  logic [ADDR_W-1:0]  local_ptr,
  input  logic [ADDR_W-1:0]  arg_ptr,
  input  logic [DATA_W-1:0]  stk_top,
  output logic [ADDR_W-1:0]  stk_idx,
  input  logic [DATA_W-1:0]  stk_rdata,
  output logic               stk_pop,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_ack,
  input  logic [TAG_W-1:0]   mem_rtag,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               done,
  output logic               is_stack,
  output logic               err,
  output logic [ADDR_W-1:0]  ea_out,
  output logic [DATA_W-1:0]  data_out,
  output logic [TAG_W-1:0]   tag_out
);
  ea_state_t         state;
  ea_kind_t          kind;
  logic [ADDR_W-1:0] calc_addr;
  logic              follow;
  logic              launch;
  logic              fin;
  logic              fin_err;
  logic [DATA_W-1:0] fin_data;
  logic [TAG_W-1:0]  fin_tag;

  opnd_base_sel #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_sel (
    .sel        (opnd_field[FIELD_W-1 -: 3]),
    .disp       (opnd_field[DISP_W-1:0]),
    .fn_ptr     (fn_ptr),
    .const_base (const_base),
    .local_ptr  (local_ptr),
    .arg_ptr    (arg_ptr),
    .addr       (calc_addr),
    .kind       (kind),
    .follow     (follow)
  );

  assign launch = start && (state == ST_IDLE) && (kind == K_MEM);

  opnd_fwd_chaser #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W),
    .FWD_TAG(FWD_TAG), .MAX_HOPS(MAX_HOPS)
  ) u_chase (
    .clk         (clk),
    .rst         (rst),
    .launch      (launch),
    .launch_addr (calc_addr),
    .follow      (follow),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .mem_rtag    (mem_rtag),
    .mem_rdata   (mem_rdata),
    .fin         (fin),
    .fin_err     (fin_err),
    .fin_data    (fin_data),
    .fin_tag     (fin_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      stk_idx  <= '0;
      stk_pop  <= 1'b0;
      done     <= 1'b0;
      is_stack <= 1'b0;
      err      <= 1'b0;
      ea_out   <= '0;
      data_out <= '0;
      tag_out  <= '0;
    end else begin
      done    <= 1'b0;
      stk_pop <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          case (kind)
            K_MEM:   state <= ST_MEM;
            K_STACK: begin
              stk_idx <= calc_addr;
              state   <= ST_STK;
            end
            default: begin
              done     <= 1'b1;
              stk_pop  <= !is_store;
              err      <= is_store;
              is_stack <= 1'b1;
              ea_out   <= '0;
              data_out <= stk_top;
              tag_out  <= '0;
            end
          endcase
        end
        ST_MEM: if (fin) begin
          done     <= 1'b1;
          err      <= fin_err;
          is_stack <= 1'b0;
          ea_out   <= mem_addr;
          data_out <= fin_data;
          tag_out  <= fin_tag;
          state    <= ST_IDLE;
        end
        default: begin
          done     <= 1'b1;
          err      <= 1'b0;
          is_stack <= 1'b1;
          ea_out   <= stk_idx;
          data_out <= stk_rdata;
          tag_out  <= '0;
          state    <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/opnd_ea_chk.sv
module opnd_ea_chk #(
  parameter int ADDR_W = 16,
  parameter int TAG_W = 3,
  parameter logic [TAG_W-1:0] FWD_TAG = '1,
  parameter int MAX_HOPS = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              err,
  input logic              is_stack,
  input logic              stk_pop,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [TAG_W-1:0]  mem_rtag,
  input logic [ADDR_W-1:0] mem_addr
);
  localparam int CW = $clog2(MAX_HOPS + 2) + 1;
  logic [CW-1:0] fwd_seen;

  always_ff @(posedge clk) begin
    if (rst || done) fwd_seen <= '0;
    else if (mem_ack && mem_rtag == FWD_TAG && fwd_seen != '1) fwd_seen <= fwd_seen + 1'b1;
  end

  AST_POP_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    stk_pop |-> (done && is_stack)); // R6
  AST_NO_POP_ON_STORE: assert property (@(posedge clk) disable iff (rst)
    stk_pop |-> !err); // R7
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R11
  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req); // R10
  AST_HOP_BOUND: assert property (@(posedge clk) disable iff (rst)
    fwd_seen <= CW'(MAX_HOPS + 1)); // R9
endmodule

bind opnd_ea_gen opnd_ea_chk #(
  .ADDR_W(ADDR_W), .TAG_W(TAG_W), .FWD_TAG(FWD_TAG), .MAX_HOPS(MAX_HOPS)
) u_chk (
  .clk(clk), .rst(rst), .done(done), .err(err), .is_stack(is_stack),
  .stk_pop(stk_pop), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_rtag(mem_rtag), .mem_addr(mem_addr)
);

// File: tb/opnd_ea_gen_test.sv
`timescale 1ns/1ps
module opnd_ea_gen_test;
  localparam int AW = 16, DW = 32, TW = 3;
  localparam logic [2:0] FWD = 3'd7;

  logic clk = 0, rst = 1, start = 0, is_store = 0;
  logic [8:0] opnd_field = '0;
  logic [AW-1:0] fn_ptr = '0, const_base = '0, local_ptr = '0, arg_ptr = '0;
  logic [DW-1:0] stk_top = '0;
  logic [AW-1:0] stk_idx, mem_addr, ea_out;
  logic [DW-1:0] stk_rdata, data_out, mem_rdata;
  logic [TW-1:0] mem_rtag, tag_out;
  logic stk_pop, mem_req, mem_ack, done, is_stack, err;

  logic [TW-1:0] mtag [256];
  logic [DW-1:0] mdat [256];
  logic [DW-1:0] smem [256];
  int lat, reads;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  opnd_ea_gen uut (.*);

  assign stk_rdata = smem[stk_idx[7:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ack <= 0; lat <= 0; reads <= 0; mem_rtag <= '0; mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      if (lat == 0) begin
        mem_ack   <= 1;
        mem_rtag  <= mtag[mem_addr[7:0]];
        mem_rdata <= mdat[mem_addr[7:0]];
        reads     <= reads + 1;
        lat       <= int'($urandom % 3);
      end else lat <= lat - 1;
    end else mem_ack <= 0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [AW-1:0] e_ea; logic [DW-1:0] e_data; logic [TW-1:0] e_tag;
  bit e_err, e_stack, e_pop; int e_reads;

  task automatic model(input logic [2:0] sel, input logic [5:0] disp, input bit st);
    logic [AW-1:0] a;
    e_err = 0; e_pop = 0; e_tag = '0; e_reads = 0;
    if (sel <= 3'd4) begin
      e_stack = 0;
      a = (sel == 3'd4) ? const_base + AW'(disp) : fn_ptr + AW'(sel) * 16'd64 + AW'(disp);
      for (int h = 0; ; h++) begin
        e_reads++;
        if (sel != 3'd4 && mtag[a[7:0]] == FWD) begin
          if (h == 16) begin e_err = 1; break; end
          a = mdat[a[7:0]][AW-1:0];
        end else break;
      end
      e_ea = a; e_data = mdat[a[7:0]]; e_tag = mtag[a[7:0]];
    end else if (sel == 3'd7) begin
      e_stack = 1; e_ea = '0; e_data = stk_top; e_err = st; e_pop = !st;
    end else begin
      e_stack = 1;
      e_ea = (sel == 3'd5) ? local_ptr + AW'(disp) : arg_ptr + AW'(disp) + 16'd1;
      e_data = smem[e_ea[7:0]];
    end
  endtask

  function automatic string rq(input logic [2:0] sel, input bit st);
    if (sel <= 3) return "R2";
    if (sel == 4) return "R3";
    if (sel == 5) return "R4";
    if (sel == 6) return "R5";
    return st ? "R7" : "R6";
  endfunction

  task automatic run_op(input logic [2:0] sel, input logic [5:0] disp,
                        input bit st, input bit poke, input string tag);
    int pops = 0, r0; bit seen = 0;
    string r = (tag != "") ? tag : rq(sel, st);
    model(sel, disp, st);
    @(negedge clk);
    r0 = reads;
    opnd_field = {sel, disp}; is_store = st; start = 1;
    @(negedge clk);
    start = 0;
    for (int c = 0; c < 400 && !seen; c++) begin
      if (c > 0) @(negedge clk);
      if (stk_pop) pops++;
      if (done) seen = 1;
      if (poke && c == 0) begin opnd_field = 9'h1C5; is_store = 1; start = 1; end
      if (poke && c == 1) start = 0;
    end
    chk(seen, r, "done seen", seen, 1);
    chk(ea_out == e_ea, r, "ea", ea_out, e_ea);
    chk(err == e_err, r, "err", err, e_err);
    chk(is_stack == e_stack, r, "is_stack", is_stack, e_stack);
    chk(pops == int'(e_pop), r, "pop count", pops, e_pop);
    if (!e_err) chk(data_out == e_data, r, "data", data_out, e_data);
    if (!e_stack) begin
      chk(tag_out == e_tag, r, "tag", tag_out, e_tag);
      chk(reads - r0 == e_reads, r, "reads", reads - r0, e_reads);
    end
    @(negedge clk);
    chk(!done && !stk_pop, "R10", "done pulse width", done, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      mtag[i] = 3'($urandom % 7);
      mdat[i] = $urandom;
      smem[i] = $urandom;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!done && !mem_req && !stk_pop && !err, "R1", "reset outputs",
        {done, mem_req, stk_pop, err}, 0);

    fn_ptr = 16'h1000; const_base = 16'h2040; local_ptr = 16'h0030;
    arg_ptr = 16'h0050; stk_top = 32'hCAFE_F00D;
    for (int s = 0; s < 8; s++) run_op(3'(s), 6'd5, 0, 0, "");
    run_op(3'd7, 6'd63, 0, 0, "R6");
    run_op(3'd7, 6'd0, 1, 0, "R7");
    mtag[8'h47] = FWD; mdat[8'h47] = 32'h0000_3011;
    run_op(3'd4, 6'd7, 0, 0, "R3");
    run_op(3'd0, 6'd63, 0, 0, "R2");
    for (int i = 0; i < 16; i++) begin
      mtag[8'h80 + i] = FWD; mdat[8'h80 + i] = 32'h0000_0081 + i;
    end
    mtag[8'h90] = 3'd2; mdat[8'h90] = 32'h1234_5678;
    fn_ptr = 16'h0040;
    run_op(3'd0, 6'd0, 0, 0, "R8");
    run_op(3'd1, 6'd0, 0, 1, "R9");
    run_op(3'd1, 6'd1, 0, 0, "R8");
    run_op(3'd1, 6'd0, 0, 1, "R10");
    mtag[8'h90] = FWD; mdat[8'h90] = 32'h0000_0091;
    run_op(3'd1, 6'd0, 0, 1, "R9");
    mtag[8'h90] = 3'd1;

    for (int n = 0; n < 250; n++) begin
      fn_ptr = 16'($urandom); const_base = 16'($urandom);
      local_ptr = 16'($urandom); arg_ptr = 16'($urandom); stk_top = $urandom;
      run_op(3'($urandom), 6'($urandom), 1'($urandom), 0, "");
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule